// File: doc/BRIEF.md
# Serial Port Control and Status Register Block

This block is the register front end of a simple serial port. A 32-bit CPU bus reaches it one word per cycle through a request strobe, a write flag and a word index. The block turns those accesses into byte traffic. A write to the transmit data word puts one byte on an outgoing strobe. Bytes that arrive on a valid/ready input land in a status word, together with a flag that marks new data. Bit-level framing, baud timing and DMA are handled elsewhere. The DMA-enable word is plain storage here.

Two addresses read the same status word. One of them clears the new-data flag as a side effect of the read; the other does not. Transmit-done and receive events collect in a raw pending word. A mask word gates the raw bits into a masked word, and any set masked bit raises the single interrupt line. Software clears pending bits by writing ones to an acknowledge word. That word always reads back as zero, because it is emptied after each access. The receive input stops accepting bytes while an unserviced receive event is pending, unless software has enabled receive in the receive control word.

Top module: `serial_csr`

## Requirements
- R1: After reset the status word (word index 8 or 9) reads 0x0140_0000: transmitter-ready at bit 24 and transmitter-idle at bit 22. Every other word reads zero, `irq` is low and `rx_ready` is high.
- R2: The word indices 0 (transmit control), 1 (DMA enable), 2 (receive control), 3 to 6, 7 (transmit data), 10 (spare) and 11 (interrupt mask) store a written value and return it on a read.
- R3: A write to index 7 raises `tx_valid` for exactly one cycle, starting the cycle after the write, with `tx_data` equal to bits [7:0] of the write data. The write also sets raw bit 0 (transmit done) and an internal transmit-pending flag.
- R4: A byte is taken when `rx_valid` and `rx_ready` are both high at a clock edge. It replaces status bits [7:0], sets the data-available bit 16 and sets raw bit 3 (receive). All other status bits are kept.
- R5: A read of index 8 returns the status word and then clears bit 16. A read of index 9 returns the same word and changes nothing.
- R6: `rx_ready` is high when bit 0 of the receive control word is set or raw bit 3 is clear. A byte offered while `rx_ready` is low leaves the status word unchanged.
- R7: A write to index 12 (acknowledge) clears each raw bit whose bit is one in the written value. Index 12 always reads zero.
- R8: An acknowledge write with bit 0 set, made while transmit-pending is set, keeps raw bit 0 set and clears transmit-pending. A second such write then clears raw bit 0.
- R9: Index 14 reads raw AND mask. `irq` is high exactly when that value is nonzero, and both update on the edge that changes raw or mask.
- R10: A write to index 13 loads the raw word. A write to index 14 or index 9 has no lasting visible effect.
- R11: A write to index 8 replaces the whole status word.
- R12: When a bus access and a byte take fall on the same edge, the access is applied first and the byte second: a received byte survives a simultaneous receive acknowledge, a status write or a clearing status read.
- R13: Index 15 lies outside the 15-word window. It reads zero and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current index, combinational |
| tx_valid | output | 1 | One-cycle transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte may be taken |
| irq | output | 1 | Interrupt request |

## Verification
A CPU register access and a byte take can land on the same clock edge, and their order decides what software sees. The bench drives a bus request and `rx_valid` in the same cycle in three forms: an acknowledge of the receive bit, a status write, and a clearing status read. It then reads back the raw word and the status alias. The received byte, the data-available bit and raw bit 3 must each show the receive update applied after the bus access.

// File: rtl/serial_csr_pkg.sv
package serial_csr_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned IDX_N    = 1 << IDX_W;

  localparam logic [IDX_W-1:0] IX_TXCTL  = 4'd0;
  localparam logic [IDX_W-1:0] IX_DMAEN  = 4'd1;
  localparam logic [IDX_W-1:0] IX_RXCTL  = 4'd2;
  localparam logic [IDX_W-1:0] IX_TXDAT  = 4'd7;
  localparam logic [IDX_W-1:0] IX_STCLR  = 4'd8;
  localparam logic [IDX_W-1:0] IX_STPEEK = 4'd9;
  localparam logic [IDX_W-1:0] IX_MASK   = 4'd11;
  localparam logic [IDX_W-1:0] IX_ACK    = 4'd12;
  localparam logic [IDX_W-1:0] IX_RAW    = 4'd13;
  localparam logic [IDX_W-1:0] IX_GATED  = 4'd14;

  // indices with plain read/write storage
  localparam logic [IDX_N-1:0] PLAIN_MAP = 16'h04FF;

  localparam int unsigned ST_DAV   = 16;
  localparam int unsigned ST_IDLE  = 22;
  localparam int unsigned ST_RDY   = 24;
  localparam logic [WORD_W-1:0] ST_INIT =
    (WORD_W'(1) << ST_RDY) | (WORD_W'(1) << ST_IDLE);

  localparam int unsigned EV_TX = 0;
  localparam int unsigned EV_RX = 3;
endpackage

// File: rtl/serial_csr_decode.sv
module serial_csr_decode
  import serial_csr_pkg::*;
#(
  parameter int unsigned AW = IDX_W,
  localparam int unsigned NW = 1 << AW
) (
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  output logic [NW-1:0] wr_hit,
  output logic          rd_clr,
  output logic          any_wr
);
  for (genvar i = 0; i < NW; i++) begin : g_hit
    assign wr_hit[i] = req & we & (addr == AW'(i));
  end

  assign rd_clr = req & ~we & (addr == IX_STCLR);
  assign any_wr = req & we;
endmodule

// File: rtl/serial_csr_store.sv
module serial_csr_store
  import serial_csr_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned NW = IDX_N,
  parameter logic [NW-1:0] MAP = PLAIN_MAP
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NW-1:0]          wr_hit,
  input  logic [DW-1:0]          wdata,
  output logic [NW-1:0][DW-1:0]  words
);
  for (genvar i = 0; i < NW; i++) begin : g_word
    if (MAP[i]) begin : g_reg
      logic [DW-1:0] q, d;
      always_comb begin
        d = q;
        if (wr_hit[i]) d = wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign words[i] = q;
    end else begin : g_none
      assign words[i] = '0;
    end
  end
endmodule

// File: rtl/serial_csr_status.sv
module serial_csr_status
  import serial_csr_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stat,
  input  logic          rd_clr,
  input  logic          rx_take,
  input  logic [7:0]    rx_byte,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] stat_q
);
  logic [DW-1:0] stat_d;

  always_comb begin
    stat_d = stat_q;
    if (wr_stat) stat_d = wdata;
    if (rd_clr)  stat_d[ST_DAV] = 1'b0;
    // receive update lands after the bus access
    if (rx_take) begin
      stat_d[7:0]    = rx_byte;
      stat_d[ST_DAV] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= ST_INIT;
    else        stat_q <= stat_d;
  end
endmodule

// File: rtl/serial_csr_irq.sv
module serial_csr_irq
  import serial_csr_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_wr,
  input  logic          wr_txdat,
  input  logic          wr_ack,
  input  logic          wr_raw,
  input  logic          wr_mask,
  input  logic          rx_take,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] raw_q,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] gated_q,
  output logic          pend_q,
  output logic          irq_q
);
  logic [DW-1:0] raw_d, mask_d, gated_d, ack_v;
  logic          pend_d, irq_d;

  always_comb begin
    raw_d  = raw_q;
    mask_d = mask_q;
    pend_d = pend_q;
    ack_v  = '0;
    if (wr_txdat) begin
      raw_d[EV_TX] = 1'b1;
      pend_d       = 1'b1;
    end
    if (wr_raw)  raw_d  = wdata;
    if (wr_mask) mask_d = wdata;
    if (wr_ack) begin
      ack_v = wdata;
      if (pend_q && wdata[EV_TX]) begin
        raw_d[EV_TX] = 1'b1;
        pend_d       = 1'b0;
        ack_v[EV_TX] = 1'b0;
      end
    end
    if (any_wr) raw_d = raw_d & ~ack_v;
    if (rx_take) raw_d[EV_RX] = 1'b1;
    gated_d = raw_d & mask_d;
    irq_d   = |gated_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= '0;
      mask_q  <= '0;
      gated_q <= '0;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      raw_q   <= raw_d;
      mask_q  <= mask_d;
      gated_q <= gated_d;
      pend_q  <= pend_d;
      irq_q   <= irq_d;
    end
  end
endmodule

// File: rtl/serial_csr.sv
module serial_csr
  import serial_csr_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned AW = IDX_W,
  localparam int unsigned NW = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          rx_ready,
  output logic          irq
);
  logic [NW-1:0]         wr_hit;
  logic                  rd_clr, any_wr, rx_take;
  logic [NW-1:0][DW-1:0] words;
  logic [DW-1:0]         stat_q, raw_q, mask_q, gated_q;
  logic                  pend_q;
  logic                  txv_d, txv_q;
  logic [7:0]            txd_d, txd_q;

  serial_csr_decode #(.AW(AW)) u_dec (
    .req(bus_req), .we(bus_we), .addr(bus_addr),
    .wr_hit(wr_hit), .rd_clr(rd_clr), .any_wr(any_wr)
  );

  serial_csr_store #(.DW(DW), .NW(NW), .MAP(NW'(PLAIN_MAP))) u_store (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(bus_wdata),
    .words(words)
  );

  assign rx_ready = words[IX_RXCTL][0] | ~raw_q[EV_RX];
  assign rx_take  = rx_valid & rx_ready;

  serial_csr_status #(.DW(DW)) u_stat (
    .clk(clk), .rst_n(rst_n), .wr_stat(wr_hit[IX_STCLR]), .rd_clr(rd_clr),
    .rx_take(rx_take), .rx_byte(rx_data), .wdata(bus_wdata),
    .stat_q(stat_q)
  );

  serial_csr_irq #(.DW(DW)) u_irq (
    .clk(clk), .rst_n(rst_n), .any_wr(any_wr),
    .wr_txdat(wr_hit[IX_TXDAT]), .wr_ack(wr_hit[IX_ACK]),
    .wr_raw(wr_hit[IX_RAW]), .wr_mask(wr_hit[IX_MASK]),
    .rx_take(rx_take), .wdata(bus_wdata),
    .raw_q(raw_q), .mask_q(mask_q), .gated_q(gated_q),
    .pend_q(pend_q), .irq_q(irq)
  );

  // transmit strobe
  always_comb begin
    txv_d = wr_hit[IX_TXDAT];
    txd_d = txd_q;
    if (wr_hit[IX_TXDAT]) txd_d = bus_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txv_q <= 1'b0;
      txd_q <= '0;
    end else begin
      txv_q <= txv_d;
      txd_q <= txd_d;
    end
  end

  assign tx_valid = txv_q;
  assign tx_data  = txd_q;

  always_comb begin
    case (bus_addr)
      IX_STCLR, IX_STPEEK: bus_rdata = stat_q;
      IX_MASK:             bus_rdata = mask_q;
      IX_ACK:              bus_rdata = '0;
      IX_RAW:              bus_rdata = raw_q;
      IX_GATED:            bus_rdata = gated_q;
      default:             bus_rdata = words[bus_addr];
    endcase
  end
endmodule

// File: rtl/serial_csr_chk.sv
module serial_csr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_we,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        tx_valid,
  input logic [7:0]  tx_data,
  input logic        rx_valid,
  input logic [7:0]  rx_data,
  input logic        rx_ready,
  input logic        irq,
  input logic [31:0] stat_q,
  input logic [31:0] raw_q,
  input logic [31:0] mask_q,
  input logic [31:0] gated_q,
  input logic        pend_q
);
  a_r3_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == 4'd7) |=>
      (tx_valid && tx_data == $past(bus_wdata[7:0]) && raw_q[0] && pend_q));

  a_r3_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_we && bus_addr == 4'd7) |=> !tx_valid);

  a_r4_rx_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=>
      (stat_q[16] && raw_q[3] && stat_q[7:0] == $past(rx_data)));

  a_r5_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_addr == 4'd8 && !(rx_valid && rx_ready)) |=>
      !stat_q[16]);

  a_r6_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> raw_q[3]);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !bus_req) |=> $stable(stat_q));

  a_r8_ack_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && bus_req && bus_we && bus_addr == 4'd12 && bus_wdata[0]) |=>
      (raw_q[0] && !pend_q));

  a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
    gated_q == (raw_q & mask_q));

  a_r9_irq_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (gated_q != 32'd0));
endmodule

bind serial_csr serial_csr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tx_valid(tx_valid),
  .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
  .rx_ready(rx_ready), .irq(irq), .stat_q(stat_q), .raw_q(raw_q),
  .mask_q(mask_q), .gated_q(gated_q), .pend_q(pend_q)
);

// File: tb/serial_csr_test.sv
module serial_csr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid, rx_ready, irq;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_csr uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic rx(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(4'd8, v);  check("R1 status", v, 32'h0140_0000);
    rd(4'd9, v);  check("R1 alias", v, 32'h0140_0000);
    rd(4'd13, v); check("R1 raw", v, 0);
    rd(4'd11, v); check("R1 mask", v, 0);
    rd(4'd7, v);  check("R1 txdat", v, 0);
    check("R1 irq", irq, 0);
    check("R1 rx_ready", rx_ready, 1);
  endtask

  task automatic t_plain;
    logic [31:0] v;
    logic [3:0] ix [6] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd6, 4'd10};
    for (int i = 0; i < 6; i++) wr(ix[i], 32'hA5A5_0000 ^ (32'h1111_1111 * i));
    for (int i = 0; i < 6; i++) begin
      rd(ix[i], v);
      check("R2 store", v, 32'hA5A5_0000 ^ (32'h1111_1111 * i));
    end
    wr(4'd2, 32'h0);
  endtask

  task automatic t_tx;
    logic [31:0] v;
    wr(4'd7, 32'h1234_56A5);
    check("R3 tx_valid", tx_valid, 1);
    check("R3 tx_data", tx_data, 8'hA5);
    @(negedge clk);
    check("R3 single", tx_valid, 0);
    rd(4'd13, v); check("R3 raw0", v, 1);
    rd(4'd7, v);  check("R2 txdat", v, 32'h1234_56A5);
  endtask

  task automatic t_ack;
    logic [31:0] v;
    wr(4'd12, 32'h1);
    rd(4'd13, v); check("R8 first ack keeps", v, 1);
    rd(4'd12, v); check("R7 ack reads zero", v, 0);
    wr(4'd12, 32'h1);
    rd(4'd13, v); check("R8 second ack clears", v, 0);
  endtask

  task automatic t_rx;
    logic [31:0] v;
    rx(8'h5A);
    rd(4'd9, v);  check("R4 capture", v, 32'h0141_005A);
    rd(4'd13, v); check("R4 raw3", v, 32'h8);
    check("R6 not ready", rx_ready, 0);
    rx(8'h11);
    rd(4'd9, v);  check("R6 ignored", v, 32'h0141_005A);
    rd(4'd8, v);  check("R5 clr read value", v, 32'h0141_005A);
    rd(4'd9, v);  check("R5 dav cleared", v, 32'h0140_005A);
    wr(4'd12, 32'h8);
    rd(4'd13, v); check("R7 ack rx", v, 0);
    check("R6 ready again", rx_ready, 1);
    rx(8'h33);
    rd(4'd9, v);  check("R5 peek", v, 32'h0141_0033);
    rd(4'd9, v);  check("R5 peek again", v, 32'h0141_0033);
    wr(4'd2, 32'h1);
    check("R6 enable ready", rx_ready, 1);
    rx(8'h44);
    rd(4'd9, v);  check("R6 taken when enabled", v, 32'h0141_0044);
    wr(4'd2, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(4'd11, 32'h8);
    check("R9 irq on", irq, 1);
    rd(4'd14, v); check("R9 gated", v, 32'h8);
    wr(4'd11, 32'h0);
    check("R9 irq off", irq, 0);
    wr(4'd13, 32'h5);
    rd(4'd13, v); check("R10 raw write", v, 32'h5);
    wr(4'd11, 32'h4);
    check("R9 irq bit2", irq, 1);
    wr(4'd14, 32'hFFFF);
    rd(4'd14, v); check("R10 gated write", v, 32'h4);
    wr(4'd9, 32'h0);
    rd(4'd9, v);  check("R10 alias write", v, 32'h0141_0044);
    wr(4'd12, 32'hFFFF_FFFF);
    rd(4'd13, v); check("R7 ack all", v, 0);
    check("R9 irq cleared", irq, 0);
    wr(4'd11, 32'h0);
  endtask

  task automatic t_stat_wr;
    logic [31:0] v;
    wr(4'd8, 32'h0000_00C3);
    rd(4'd9, v); check("R11 status write", v, 32'h0000_00C3);
  endtask

  task automatic t_window;
    logic [31:0] v;
    wr(4'd15, 32'hDEAD_BEEF);
    rd(4'd15, v); check("R13 outside", v, 0);
  endtask

  task automatic t_same;
    logic [31:0] v;
    wr(4'd2, 32'h1);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 4'd12; bus_wdata = 32'h8;
    rx_valid = 1; rx_data = 8'h77;
    @(negedge clk);
    bus_req = 0; bus_we = 0; rx_valid = 0;
    rd(4'd13, v); check("R12 ack vs rx", v, 32'h8);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 4'd8; bus_wdata = 32'h0;
    rx_valid = 1; rx_data = 8'h99;
    @(negedge clk);
    bus_req = 0; bus_we = 0; rx_valid = 0;
    rd(4'd9, v); check("R12 write vs rx", v, 32'h0001_0099);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = 4'd8;
    rx_valid = 1; rx_data = 8'hEE;
    #1 v = bus_rdata;
    check("R12 read value", v, 32'h0001_0099);
    @(negedge clk);
    bus_req = 0; rx_valid = 0;
    rd(4'd9, v); check("R12 read vs rx", v, 32'h0001_00EE);
    wr(4'd2, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_plain;
    t_tx;
    t_ack;
    t_rx;
    t_irq;
    t_stat_wr;
    t_window;
    t_same;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule